// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sits beside a processor core and reacts when the core reports that it has just executed a stop instruction. On that single-cycle strobe it samples a small group of configuration bits: stop permission, debug permission, the supply-monitor enable and its keep-in-stop partner, and two power-down selects. It resolves them in a fixed priority into one of five stop depths, or into an illegal-opcode reset request when stopping is not permitted. While a stop depth is held, the bus and CPU clock enables are low. The block also drives a regulator keep-alive flag and a debug clock-keep flag when the chosen depth calls for them.

Leaving a stop depth depends on the depth. The state-retaining depths accept the external reset and five interrupt lines. The intermediate depth accepts only the external reset and the external IRQ line. The deepest depth accepts only the external reset. On wake the clock enables come back first. One cycle later a single-cycle exit strobe is raised together with a cause bit. The cause bit tells the core whether to fetch the reset vector or the interrupt vector.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A stop strobe in run mode with `cfg_stop_en_i`=0 produces `illegal_rst_o`=1 for exactly the next cycle, and `mode_o` stays 0 (run).
- R2: A stop strobe in run mode with stop and debug permission both set gives `mode_o`=3 on the next cycle, with `dbg_clk_keep_o`=1, regardless of the other configuration bits.
- R3: With stop permitted, debug clear, and both `cfg_mon_en_i` and `cfg_mon_stop_en_i` set, the strobe gives `mode_o`=2, and `reg_keep_on_o`=1 for as long as that mode is held.
- R4: With stop permitted, debug clear and either monitor bit clear: `cfg_pdc_i`=0 gives `mode_o`=1; `cfg_pdc_i`=1 with `cfg_ppdc_i`=0 gives `mode_o`=4; `cfg_pdc_i`=1 with `cfg_ppdc_i`=1 gives `mode_o`=5.
- R5: `bus_clk_en_o` and `cpu_clk_en_o` are 0 in every cycle where `mode_o` is not 0 and 1 in every cycle where it is 0.
- R6: In modes 1, 2 and 3, `ext_rst_i` or any `wake_i` line ends the mode on the next cycle. The lines are bit 0 real-time tick, bit 1 supply monitor, bit 2 converter done, bit 3 external IRQ, bit 4 keypad.
- R7: In mode 4 only `ext_rst_i` or `wake_i[3]` ends the mode, and in mode 5 only `ext_rst_i` does. Every exit from modes 4 and 5 reports `exit_reset_o`=1.
- R8: Exiting modes 1 to 3 reports `exit_reset_o`=1 when `ext_rst_i` was high in the wake cycle, and 0 (interrupt vector) otherwise.
- R9: In run mode, `wake_i` and `ext_rst_i` have no effect: no exit strobe, no mode change.
- R10: Wake inputs present in the same cycle as the stop strobe are kept, provided they are permitted for the chosen mode. The mode is entered for one cycle and then left.
- R11: The clock enables rise one cycle before `exit_valid_o`, which is a single-cycle pulse.
- R12: Configuration changes and stop strobes that arrive while a stop mode is held do not change the held mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the controller |
| stop_strobe_i | input | 1 | Single-cycle pulse: core executed a stop instruction |
| cfg_stop_en_i | input | 1 | Stop instruction permitted |
| cfg_dbg_en_i | input | 1 | Background debug enabled |
| cfg_mon_en_i | input | 1 | Supply monitor enabled |
| cfg_mon_stop_en_i | input | 1 | Supply monitor kept on in stop |
| cfg_pdc_i | input | 1 | Power-down select |
| cfg_ppdc_i | input | 1 | Partial power-down select |
| wake_i | input | NUM_WAKE | Interrupt wake lines (bit map in R6) |
| ext_rst_i | input | 1 | External reset request |
| mode_o | output | 3 | Mode code: 0 run, 1 retain, 2 retain+regulator, 3 retain+debug, 4 intermediate, 5 deepest |
| bus_clk_en_o | output | 1 | Bus clock enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| reg_keep_on_o | output | 1 | Keep voltage regulator active |
| dbg_clk_keep_o | output | 1 | Keep internal clocks running for debug |
| illegal_rst_o | output | 1 | Illegal-opcode reset request pulse |
| exit_valid_o | output | 1 | Stop exit strobe |
| exit_reset_o | output | 1 | Exit cause: 1 reset vector, 0 interrupt vector |

## Verification
A wrong priority in the decode shows up in `mode_o` on the cycle right after the strobe, so every strobe in the bench is checked one clock later. A wake mask that admits or drops a line shows up as a mode that is left too early or held too long. Each stop cycle compares `mode_o` with the expected held value, so this is caught in the same cycle. A broken exit pipeline changes the spacing between the clock enables rising and the exit pulse, or flips the cause bit. Both are checked two cycles after the wake.

// File: rtl/stop_pkg.sv
package stop_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN    = 3'd0,
        MODE_S3     = 3'd1,
        MODE_S3_REG = 3'd2,
        MODE_S3_DBG = 3'd3,
        MODE_S2     = 3'd4,
        MODE_S1     = 3'd5
    } stop_mode_e;

    typedef struct packed {
        logic stop_en;
        logic dbg_en;
        logic mon_en;
        logic mon_stop_en;
        logic pdc;
        logic ppdc;
    } stop_cfg_t;

    typedef struct packed {
        stop_mode_e mode;
        logic       clk_en;
        logic       early;
        logic       early_rst;
        logic       illegal;
        logic       exit_pend;
        logic       pend_rst;
        logic       exit_valid;
        logic       exit_rst;
    } ctrl_state_t;

endpackage

// File: rtl/stop_mode_decode.sv
module stop_mode_decode
    import stop_pkg::*;
(
    input  stop_cfg_t  cfg_i,
    output stop_mode_e mode_o,
    output logic       illegal_o
);

    always_comb begin
        illegal_o = !cfg_i.stop_en;
        mode_o    = MODE_RUN;
        if (cfg_i.stop_en) begin
            if (cfg_i.dbg_en) begin
                mode_o = MODE_S3_DBG;
            end else if (cfg_i.mon_en && cfg_i.mon_stop_en) begin
                mode_o = MODE_S3_REG;
            end else if (!cfg_i.pdc) begin
                mode_o = MODE_S3;
            end else if (!cfg_i.ppdc) begin
                mode_o = MODE_S2;
            end else begin
                mode_o = MODE_S1;
            end
        end
    end

endmodule

// File: rtl/stop_wake_qual.sv
module stop_wake_qual
    import stop_pkg::*;
#(
    parameter int NUM_WAKE = 5,
    parameter int IRQ_IDX  = 3
) (
    input  stop_mode_e          mode_i,
    input  logic [NUM_WAKE-1:0] wake_i,
    input  logic                ext_rst_i,
    output logic                wake_o,
    output logic                rst_type_o
);

    logic                retain;
    logic                mid;
    logic                deep;
    logic [NUM_WAKE-1:0] hit;

    assign retain = (mode_i == MODE_S3) || (mode_i == MODE_S3_REG) ||
                    (mode_i == MODE_S3_DBG);
    assign mid    = (mode_i == MODE_S2);
    assign deep   = mid || (mode_i == MODE_S1);

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_line
        localparam logic IS_IRQ = (g == IRQ_IDX);
        assign hit[g] = wake_i[g] & (retain | (mid & IS_IRQ));
    end

    assign wake_o     = ext_rst_i | (|hit);
    assign rst_type_o = ext_rst_i | (deep & (|hit));

endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
    import stop_pkg::*;
#(
    parameter int NUM_WAKE = 5,
    parameter int IRQ_IDX  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_strobe_i,
    input  logic                cfg_stop_en_i,
    input  logic                cfg_dbg_en_i,
    input  logic                cfg_mon_en_i,
    input  logic                cfg_mon_stop_en_i,
    input  logic                cfg_pdc_i,
    input  logic                cfg_ppdc_i,
    input  logic [NUM_WAKE-1:0] wake_i,
    input  logic                ext_rst_i,
    output logic [MODE_W-1:0]   mode_o,
    output logic                bus_clk_en_o,
    output logic                cpu_clk_en_o,
    output logic                reg_keep_on_o,
    output logic                dbg_clk_keep_o,
    output logic                illegal_rst_o,
    output logic                exit_valid_o,
    output logic                exit_reset_o
);

    stop_cfg_t   cfg;
    stop_mode_e  dec_mode;
    logic        dec_illegal;
    logic        early_wake;
    logic        early_rst;
    logic        live_wake;
    logic        live_rst;
    ctrl_state_t st_d;
    ctrl_state_t st_q;

    assign cfg = '{stop_en:     cfg_stop_en_i,
                   dbg_en:      cfg_dbg_en_i,
                   mon_en:      cfg_mon_en_i,
                   mon_stop_en: cfg_mon_stop_en_i,
                   pdc:         cfg_pdc_i,
                   ppdc:        cfg_ppdc_i};

    stop_mode_decode u_decode (
        .cfg_i     (cfg),
        .mode_o    (dec_mode),
        .illegal_o (dec_illegal)
    );

    // Wake qualified against the mode about to be entered (same-cycle wake)
    stop_wake_qual #(.NUM_WAKE(NUM_WAKE), .IRQ_IDX(IRQ_IDX)) u_wake_entry (
        .mode_i     (dec_mode),
        .wake_i     (wake_i),
        .ext_rst_i  (ext_rst_i),
        .wake_o     (early_wake),
        .rst_type_o (early_rst)
    );

    // Wake qualified against the mode currently held
    stop_wake_qual #(.NUM_WAKE(NUM_WAKE), .IRQ_IDX(IRQ_IDX)) u_wake_held (
        .mode_i     (st_q.mode),
        .wake_i     (wake_i),
        .ext_rst_i  (ext_rst_i),
        .wake_o     (live_wake),
        .rst_type_o (live_rst)
    );

    always_comb begin
        st_d            = st_q;
        st_d.illegal    = 1'b0;
        st_d.exit_valid = 1'b0;
        st_d.exit_rst   = 1'b0;

        // Second stage of the exit: clocks already running, now flag the cause
        if (st_q.exit_pend) begin
            st_d.exit_valid = 1'b1;
            st_d.exit_rst   = st_q.pend_rst;
            st_d.exit_pend  = 1'b0;
            st_d.pend_rst   = 1'b0;
        end

        if (st_q.mode == MODE_RUN) begin
            if (stop_strobe_i) begin
                if (dec_illegal) begin
                    st_d.illegal = 1'b1;
                end else begin
                    st_d.mode      = dec_mode;
                    st_d.clk_en    = 1'b0;
                    st_d.early     = early_wake;
                    st_d.early_rst = early_wake & early_rst;
                end
            end
        end else if (live_wake || st_q.early) begin
            st_d.mode      = MODE_RUN;
            st_d.clk_en    = 1'b1;
            st_d.early     = 1'b0;
            st_d.early_rst = 1'b0;
            st_d.exit_pend = 1'b1;
            st_d.pend_rst  = (live_wake & live_rst) | st_q.early_rst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode:       MODE_RUN,
                      clk_en:     1'b1,
                      early:      1'b0,
                      early_rst:  1'b0,
                      illegal:    1'b0,
                      exit_pend:  1'b0,
                      pend_rst:   1'b0,
                      exit_valid: 1'b0,
                      exit_rst:   1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o         = st_q.mode;
    assign bus_clk_en_o   = st_q.clk_en;
    assign cpu_clk_en_o   = st_q.clk_en;
    assign reg_keep_on_o  = (st_q.mode == MODE_S3_REG);
    assign dbg_clk_keep_o = (st_q.mode == MODE_S3_DBG);
    assign illegal_rst_o  = st_q.illegal;
    assign exit_valid_o   = st_q.exit_valid;
    assign exit_reset_o   = st_q.exit_rst;

endmodule

// File: rtl/stop_mode_ctrl_chk.sv
module stop_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_strobe_i,
    input logic       cfg_stop_en_i,
    input logic       cfg_dbg_en_i,
    input logic       ext_rst_i,
    input logic [2:0] mode_o,
    input logic       bus_clk_en_o,
    input logic       cpu_clk_en_o,
    input logic       reg_keep_on_o,
    input logic       illegal_rst_o,
    input logic       exit_valid_o,
    input logic       exit_reset_o
);

    p_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && stop_strobe_i && !cfg_stop_en_i)
        |=> (illegal_rst_o && mode_o == 3'd0));

    p_dbg_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && stop_strobe_i && cfg_stop_en_i && cfg_dbg_en_i)
        |=> (mode_o == 3'd3));

    p_reg_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_keep_on_o == (mode_o == 3'd2));

    p_clk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 3'd0) |-> (!bus_clk_en_o && !cpu_clk_en_o));

    p_clk_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0) |-> (bus_clk_en_o && cpu_clk_en_o));

    p_deep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5 && $past(mode_o) == 3'd5 && !ext_rst_i)
        |=> (mode_o == 3'd5));

    p_deep_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_valid_o && $past(mode_o, 2) >= 3'd4) |-> exit_reset_o);

    p_run_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && !stop_strobe_i) |=> (mode_o == 3'd0));

    p_exit_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk_en_o) |=> exit_valid_o);

    p_exit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid_o |=> !exit_valid_o);

endmodule

bind stop_mode_ctrl stop_mode_ctrl_chk u_chk (.*);

// File: tb/tb_stop_mode_ctrl.sv
module tb_stop_mode_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_strobe_i = 1'b0;
    logic       cfg_stop_en_i = 1'b0;
    logic       cfg_dbg_en_i = 1'b0;
    logic       cfg_mon_en_i = 1'b0;
    logic       cfg_mon_stop_en_i = 1'b0;
    logic       cfg_pdc_i = 1'b0;
    logic       cfg_ppdc_i = 1'b0;
    logic [4:0] wake_i = '0;
    logic       ext_rst_i = 1'b0;
    logic [2:0] mode_o;
    logic       bus_clk_en_o;
    logic       cpu_clk_en_o;
    logic       reg_keep_on_o;
    logic       dbg_clk_keep_o;
    logic       illegal_rst_o;
    logic       exit_valid_o;
    logic       exit_reset_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_mode_ctrl dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .stop_strobe_i     (stop_strobe_i),
        .cfg_stop_en_i     (cfg_stop_en_i),
        .cfg_dbg_en_i      (cfg_dbg_en_i),
        .cfg_mon_en_i      (cfg_mon_en_i),
        .cfg_mon_stop_en_i (cfg_mon_stop_en_i),
        .cfg_pdc_i         (cfg_pdc_i),
        .cfg_ppdc_i        (cfg_ppdc_i),
        .wake_i            (wake_i),
        .ext_rst_i         (ext_rst_i),
        .mode_o            (mode_o),
        .bus_clk_en_o      (bus_clk_en_o),
        .cpu_clk_en_o      (cpu_clk_en_o),
        .reg_keep_on_o     (reg_keep_on_o),
        .dbg_clk_keep_o    (dbg_clk_keep_o),
        .illegal_rst_o     (illegal_rst_o),
        .exit_valid_o      (exit_valid_o),
        .exit_reset_o      (exit_reset_o)
    );

    // cfg vector: [5] stop_en [4] dbg [3] mon [2] mon_stop [1] pdc [0] ppdc
    function automatic logic [2:0] exp_mode(input logic [5:0] c);
        if (!c[5])              return 3'd0;
        if (c[4])               return 3'd3;
        if (c[3] && c[2])       return 3'd2;
        if (!c[1])              return 3'd1;
        if (!c[0])              return 3'd4;
        return 3'd5;
    endfunction

    function automatic logic wake_ok(input logic [2:0] m, input logic [4:0] w, input logic r);
        if (r) return 1'b1;
        if (m >= 3'd1 && m <= 3'd3) return |w;
        if (m == 3'd4) return w[3];
        return 1'b0;
    endfunction

    function automatic logic rst_type(input logic [2:0] m, input logic r);
        return r || (m >= 3'd4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [5:0] c);
        {cfg_stop_en_i, cfg_dbg_en_i, cfg_mon_en_i, cfg_mon_stop_en_i, cfg_pdc_i, cfg_ppdc_i} = c;
    endtask

    task automatic clear_in();
        stop_strobe_i = 1'b0;
        wake_i        = '0;
        ext_rst_i     = 1'b0;
    endtask

    // Called right after the wake edge
    task automatic check_exit(input logic cause, input string req);
        chk({req, " mode run after wake"}, mode_o, 3'd0);
        chk("R5 clocks back on", {bus_clk_en_o, cpu_clk_en_o}, 2'b11);
        chk("R11 exit not yet flagged", exit_valid_o, 1'b0);
        tick();
        chk("R11 exit strobe", exit_valid_o, 1'b1);
        chk({req, " exit cause"}, exit_reset_o, cause);
        tick();
        chk("R11 exit pulse single", exit_valid_o, 1'b0);
    endtask

    // Strobe with cfg c and same-cycle wake inputs ew/er; leaves the block in
    // the stop mode (returns expected mode) or handles immediate outcomes.
    task automatic enter(input logic [5:0] c, input logic [4:0] ew, input logic er,
                         output logic [2:0] m, output logic done);
        m = exp_mode(c);
        done = 1'b0;
        set_cfg(c);
        stop_strobe_i = 1'b1;
        wake_i        = ew;
        ext_rst_i     = er;
        tick();
        clear_in();
        if (m == 3'd0) begin
            chk("R1 illegal request", illegal_rst_o, 1'b1);
            chk("R1 stays run", mode_o, 3'd0);
            tick();
            chk("R1 illegal single", illegal_rst_o, 1'b0);
            done = 1'b1;
            return;
        end
        chk(m == 3'd3 ? "R2 mode" : m == 3'd2 ? "R3 mode" : "R4 mode", mode_o, m);
        chk("R5 clocks off", {bus_clk_en_o, cpu_clk_en_o}, 2'b00);
        chk("R3 regulator flag", reg_keep_on_o, m == 3'd2);
        chk("R2 debug clock flag", dbg_clk_keep_o, m == 3'd3);
        chk("R1 no illegal", illegal_rst_o, 1'b0);
        if (wake_ok(m, ew, er)) begin
            tick();
            check_exit(rst_type(m, er), "R10");
            done = 1'b1;
        end
    endtask

    task automatic random_case(input logic [5:0] c, input logic [4:0] ew, input logic er);
        logic [2:0] m;
        logic       done;
        enter(c, ew, er, m, done);
        if (done) return;
        for (int i = 0; i < 40; i++) begin
            logic [4:0] w;
            logic       r;
            w = ($urandom % 4 == 0) ? (5'b1 << ($urandom % 5)) : 5'b0;
            r = ($urandom % 16 == 0) || (i == 39);
            set_cfg(6'($urandom));
            stop_strobe_i = ($urandom % 8 == 0);
            wake_i        = w;
            ext_rst_i     = r;
            tick();
            clear_in();
            if (wake_ok(m, w, r)) begin
                check_exit(rst_type(m, r), (m >= 3'd4) ? "R7" : (r ? "R8" : "R6"));
                return;
            end
            chk((m >= 3'd4) ? "R7 held" : "R12 held", mode_o, m);
        end
    endtask

    initial begin
        logic [2:0] m;
        logic       done;
        void'($urandom(32'h1d5c_07e3));
        clear_in();
        repeat (3) @(posedge clk);
        #1;
        chk("R5 reset mode run", mode_o, 3'd0);
        chk("R5 reset clocks on", {bus_clk_en_o, cpu_clk_en_o}, 2'b11);
        chk("R11 reset no exit", exit_valid_o, 1'b0);
        chk("R1 reset no illegal", illegal_rst_o, 1'b0);
        rst_n = 1'b1;
        tick();

        // R9: wake inputs in run mode are ignored
        wake_i = 5'h1f;
        ext_rst_i = 1'b1;
        repeat (3) begin
            tick();
            chk("R9 run ignores wake", mode_o, 3'd0);
            chk("R9 no exit in run", exit_valid_o, 1'b0);
        end
        clear_in();
        tick();

        // R1 directed
        enter(6'b011111, 5'h0, 1'b0, m, done);

        // R7: intermediate mode ignores keypad, wakes on IRQ as reset-type
        enter(6'b100010, 5'h0, 1'b0, m, done);
        wake_i = 5'b10000; tick(); clear_in();
        chk("R7 keypad ignored in mode 4", mode_o, 3'd4);
        wake_i = 5'b01000; tick(); clear_in();
        check_exit(1'b1, "R7");

        // R7: deepest mode ignores IRQ
        enter(6'b100011, 5'h0, 1'b0, m, done);
        wake_i = 5'b01000; tick(); clear_in();
        chk("R7 IRQ ignored in mode 5", mode_o, 3'd5);
        ext_rst_i = 1'b1; tick(); clear_in();
        check_exit(1'b1, "R7");

        // R8: converter interrupt gives interrupt vector; reset wins over rti
        enter(6'b100000, 5'h0, 1'b0, m, done);
        wake_i = 5'b00100; tick(); clear_in();
        check_exit(1'b0, "R8");
        enter(6'b101100, 5'h0, 1'b0, m, done);
        wake_i = 5'b00001; ext_rst_i = 1'b1; tick(); clear_in();
        check_exit(1'b1, "R8");

        // R2: debug wins over everything
        enter(6'b111111, 5'h0, 1'b0, m, done);
        stop_strobe_i = 1'b1; set_cfg(6'b100011); tick(); clear_in();
        chk("R12 strobe in stop ignored", mode_o, 3'd3);
        wake_i = 5'b00010; tick(); clear_in();
        check_exit(1'b0, "R6");

        // R10: same-cycle permitted wake, and a same-cycle non-permitted one
        enter(6'b100000, 5'b10000, 1'b0, m, done);
        chk("R10 immediate wake taken", done, 1'b1);
        enter(6'b100011, 5'b01000, 1'b0, m, done);
        chk("R10 disallowed early wake dropped", done, 1'b0);
        tick();
        chk("R10 deep mode still held", mode_o, 3'd5);
        ext_rst_i = 1'b1; tick(); clear_in();
        check_exit(1'b1, "R7");

        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [4:0] ew;
            logic       er;
            ew = ($urandom % 6 == 0) ? 5'($urandom) : 5'b0;
            er = ($urandom % 12 == 0);
            random_case(6'($urandom), ew, er);
            tick();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule